// File: doc/BRIEF.md
# Shared Square-Wave / Alarm Interrupt Pin Controller

This block owns one 8-bit control register and drives a single active-low output pin that is shared between two uses. In square-wave mode the pin carries a 50% duty clock at one of four rates, produced by dividing a 32768 Hz tick enable. In interrupt mode the pin is pulled low whenever an alarm flag is set and that alarm is enabled. Two alarm flags latch the match pulses from an external comparator in either mode, and software clears them through a write-zero-to-clear port.

A battery-mode indicator changes what the block does. On battery, the pin can be released to high impedance, and setting the oscillator-stop bit freezes all of the block's state. On main power the divider always runs, whatever that bit holds. Any write that changes the rate code or the mode bit restarts the divider from a clean high level, so the new setting never produces a runt pulse.

Top module: `sqw_alarm_out`

## Requirements
- R1: After reset, `ctrl_rd` is 0x1C, both flags are 0, `pin_n` is 1 and `pin_oe` is 1.
- R2: A control write stores all 8 bits and `ctrl_rd` returns them the next cycle. Bit 7 is oscillator stop, bit 6 is battery drive, bit 5 is a stored conversion-request bit, bits 4:3 are the rate code, bit 2 is the mode (1 = interrupt, 0 = square wave), bit 1 enables alarm 2 and bit 0 enables alarm 1.
- R3: In square-wave mode each level of the wave lasts this many ticks: rate code 00 gives 16384 (1 Hz), 01 gives 16 (1024 Hz), 10 gives 4 (4096 Hz) and 11 gives 2 (8192 Hz).
- R4: In square-wave mode `pin_n` follows the square wave, and set or enabled alarm flags have no effect on it.
- R5: In interrupt mode `pin_n` is 0 exactly when (alarm-1 flag AND enable bit 0) OR (alarm-2 flag AND enable bit 1), and is 1 otherwise.
- R6: A one-cycle pulse on `alm1_hit` or `alm2_hit` sets `flag_a1` or `flag_a2` on the next cycle, whatever the mode and enable bits hold.
- R7: A flag stays set until a clear write puts 0 in its bit of `clr_data` (bit 0 is alarm 1, bit 1 is alarm 2). A 1 in a bit leaves that flag unchanged. A match in the same cycle as a clear leaves the flag set.
- R8: With `on_battery` = 1 and bit 6 = 0, `pin_oe` is 0 and `pin_n` is 1. In every other case `pin_oe` is 1.
- R9: With `on_battery` = 1 and bit 7 = 1, ticks, alarm pulses, control writes and clear writes have no effect. On main power, bit 7 does not stop the divider.
- R10: A control write that changes bits 4:2 restarts the divider: `pin_n` goes high and the next level lasts a full count. A write that leaves bits 4:2 unchanged does not disturb the divider's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_tick | input | 1 | One-cycle 32768 Hz tick enable |
| wr_en | input | 1 | Control register write strobe |
| wr_data | input | 8 | Control register write data |
| clr_en | input | 1 | Flag clear write strobe |
| clr_data | input | 2 | Flag clear data, 0 clears that flag |
| alm1_hit | input | 1 | Alarm 1 match pulse |
| alm2_hit | input | 1 | Alarm 2 match pulse |
| on_battery | input | 1 | 1 when running from the backup supply |
| ctrl_rd | output | 8 | Control register readback |
| flag_a1 | output | 1 | Alarm 1 flag |
| flag_a2 | output | 1 | Alarm 2 flag |
| pin_n | output | 1 | Active-low shared pin value |
| pin_oe | output | 1 | Pin output enable, 0 = high impedance |

## Verification
All four rate codes are run with one tick per cycle, and the ticks in each half period are counted. A wrong divisor or a lopsided duty cycle shows up as a wrong count. In interrupt mode, flags and enables are set one at a time and in crossed pairs, which separates a correct per-alarm gate from one that ORs the enables or swaps the two alarms. In square-wave mode, set and enabled flags are shown to leave the wave alone. Writes that change the rate or mode in the middle of a count are set against writes that touch only the enable bits, which separates a real restart from a divider that resets on every write. The battery cases run with both settings of the drive bit and of the stop bit, and check that stimulus is ignored while the block is frozen but not on main power.

// File: rtl/sqw_alarm_pkg.sv
package sqw_alarm_pkg;

  typedef struct packed {
    logic       osc_off;
    logic       bat_drive;
    logic       conv_req;
    logic [1:0] rate;
    logic       irq_mode;
    logic       alm2_en;
    logic       alm1_en;
  } ctrl_t;

  localparam int NUM_ALM = 2;

endpackage

// File: rtl/sqw_rst_sync.sv
module sqw_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];

endmodule

// File: rtl/sqw_ctrl_reg.sv
module sqw_ctrl_reg
  import sqw_alarm_pkg::*;
#(
  parameter logic [7:0] CTRL_RST = 8'h1C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       on_battery,
  output ctrl_t      ctrl_q,
  output logic       frozen,
  output logic       restart
);

  ctrl_t ctrl_d;
  ctrl_t wr_val;
  logic  wr_ok;

  assign wr_val = ctrl_t'(wr_data);
  assign frozen = on_battery & ctrl_q.osc_off;
  assign wr_ok  = wr_en & ~frozen;

  // A change of rate code or mode restarts the divider
  assign restart = wr_ok &
                   ({wr_val.rate, wr_val.irq_mode} != {ctrl_q.rate, ctrl_q.irq_mode});

  always_comb begin
    ctrl_d = ctrl_q;
    if (wr_ok) ctrl_d = wr_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= ctrl_t'(CTRL_RST);
    else        ctrl_q <= ctrl_d;
  end

  assert_frozen_ctrl_R9: assert property (@(posedge clk) disable iff (!rst_n)
    frozen |=> $stable(ctrl_q));

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !frozen) |=> (ctrl_q == $past(wr_data)));

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int REF_HZ = 32768,
  parameter int RATE_0 = 1,
  parameter int RATE_1 = 1024,
  parameter int RATE_2 = 4096,
  parameter int RATE_3 = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       frozen,
  input  logic       restart,
  input  logic [1:0] rate,
  output logic       sqw
);

  localparam int HALF_0 = REF_HZ / (2 * RATE_0);
  localparam int HALF_1 = REF_HZ / (2 * RATE_1);
  localparam int HALF_2 = REF_HZ / (2 * RATE_2);
  localparam int HALF_3 = REF_HZ / (2 * RATE_3);
  localparam int CNT_W  = (HALF_0 > 2) ? $clog2(HALF_0) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_d, half_m1;
  logic             sqw_q, sqw_d;
  logic             wrap;

  always_comb begin
    unique case (rate)
      2'b00:   half_m1 = CNT_W'(HALF_0 - 1);
      2'b01:   half_m1 = CNT_W'(HALF_1 - 1);
      2'b10:   half_m1 = CNT_W'(HALF_2 - 1);
      default: half_m1 = CNT_W'(HALF_3 - 1);
    endcase
  end

  assign wrap = (cnt_q == half_m1);

  always_comb begin
    cnt_d = cnt_q;
    sqw_d = sqw_q;
    if (restart) begin
      cnt_d = '0;
      sqw_d = 1'b1;
    end else if (tick && !frozen) begin
      if (wrap) begin
        cnt_d = '0;
        sqw_d = ~sqw_q;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sqw_q <= 1'b1;
    end else begin
      cnt_q <= cnt_d;
      sqw_q <= sqw_d;
    end
  end

  assign sqw = sqw_q;

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= half_m1);

  assert_restart_clean_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0 && sqw_q));

  assert_frozen_div_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !restart) |=> ($stable(cnt_q) && $stable(sqw_q)));

endmodule

// File: rtl/sqw_alarm_flags.sv
module sqw_alarm_flags
  import sqw_alarm_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               frozen,
  input  logic [NUM_ALM-1:0] hit,
  input  logic               clr_en,
  input  logic [NUM_ALM-1:0] clr_data,
  output logic [NUM_ALM-1:0] flag
);

  for (genvar i = 0; i < NUM_ALM; i++) begin : g_flag
    logic flag_q, flag_d;

    always_comb begin
      flag_d = flag_q;
      if (!frozen) begin
        if (clr_en && !clr_data[i]) flag_d = 1'b0;
        if (hit[i])                 flag_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q <= 1'b0;
      else        flag_q <= flag_d;
    end

    assign flag[i] = flag_q;

    assert_match_sets_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (hit[i] && !frozen) |=> flag_q);

    assert_flag_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q && !(clr_en && !clr_data[i])) |=> flag_q);
  end

endmodule

// File: rtl/sqw_pin_mux.sv
module sqw_pin_mux (
  input  logic       sqw,
  input  logic       irq_mode,
  input  logic [1:0] alm_en,
  input  logic [1:0] flag,
  input  logic       on_battery,
  input  logic       bat_drive,
  output logic       pin_n,
  output logic       pin_oe
);

  logic irq_act;
  logic level;

  assign irq_act = |(flag & alm_en);
  assign level   = irq_mode ? ~irq_act : sqw;
  assign pin_oe  = ~on_battery | bat_drive;
  assign pin_n   = pin_oe ? level : 1'b1;

endmodule

// File: rtl/sqw_alarm_out.sv
module sqw_alarm_out
  import sqw_alarm_pkg::*;
#(
  parameter int         REF_HZ   = 32768,
  parameter int         RATE_0   = 1,
  parameter int         RATE_1   = 1024,
  parameter int         RATE_2   = 4096,
  parameter int         RATE_3   = 8192,
  parameter logic [7:0] CTRL_RST = 8'h1C
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       wr_en,
  input  logic [7:0] wr_data,
  input  logic       clr_en,
  input  logic [1:0] clr_data,
  input  logic       alm1_hit,
  input  logic       alm2_hit,
  input  logic       on_battery,
  output logic [7:0] ctrl_rd,
  output logic       flag_a1,
  output logic       flag_a2,
  output logic       pin_n,
  output logic       pin_oe
);

  logic               rst_i;
  ctrl_t              ctrl;
  logic               frozen;
  logic               restart;
  logic               sqw;
  logic [NUM_ALM-1:0] flags;

  sqw_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_i)
  );

  sqw_ctrl_reg #(.CTRL_RST(CTRL_RST)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_i),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .on_battery (on_battery),
    .ctrl_q     (ctrl),
    .frozen     (frozen),
    .restart    (restart)
  );

  sqw_divider #(
    .REF_HZ(REF_HZ), .RATE_0(RATE_0), .RATE_1(RATE_1),
    .RATE_2(RATE_2), .RATE_3(RATE_3)
  ) u_div (
    .clk     (clk),
    .rst_n   (rst_i),
    .tick    (ref_tick),
    .frozen  (frozen),
    .restart (restart),
    .rate    (ctrl.rate),
    .sqw     (sqw)
  );

  sqw_alarm_flags u_flags (
    .clk      (clk),
    .rst_n    (rst_i),
    .frozen   (frozen),
    .hit      ({alm2_hit, alm1_hit}),
    .clr_en   (clr_en),
    .clr_data (clr_data),
    .flag     (flags)
  );

  sqw_pin_mux u_mux (
    .sqw        (sqw),
    .irq_mode   (ctrl.irq_mode),
    .alm_en     ({ctrl.alm2_en, ctrl.alm1_en}),
    .flag       (flags),
    .on_battery (on_battery),
    .bat_drive  (ctrl.bat_drive),
    .pin_n      (pin_n),
    .pin_oe     (pin_oe)
  );

  assign ctrl_rd = ctrl;
  assign flag_a1 = flags[0];
  assign flag_a2 = flags[1];

  assert_quiet_pin_R5: assert property (@(posedge clk) disable iff (!rst_i)
    (ctrl.irq_mode && !flags[0] && !flags[1]) |-> pin_n);

  assert_hiz_idle_R8: assert property (@(posedge clk) disable iff (!rst_i)
    !pin_oe |-> (pin_n && on_battery));

endmodule

// File: tb/sim_sqw_alarm_out.sv
module sim_sqw_alarm_out;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ref_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       clr_en = 1'b0;
  logic [1:0] clr_data = 2'b11;
  logic       alm1_hit = 1'b0;
  logic       alm2_hit = 1'b0;
  logic       on_battery = 1'b0;
  logic [7:0] ctrl_rd;
  logic       flag_a1, flag_a2, pin_n, pin_oe;

  int vec_cnt = 0;
  int bad_cnt = 0;

  always #2 clk = ~clk;

  sqw_alarm_out u0 (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .wr_en(wr_en),
    .wr_data(wr_data), .clr_en(clr_en), .clr_data(clr_data),
    .alm1_hit(alm1_hit), .alm2_hit(alm2_hit), .on_battery(on_battery),
    .ctrl_rd(ctrl_rd), .flag_a1(flag_a1), .flag_a2(flag_a2),
    .pin_n(pin_n), .pin_oe(pin_oe)
  );

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    vec_cnt++;
    if (act !== exp) begin
      bad_cnt++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // All tasks start and end at a falling edge
  task automatic wr_ctrl(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic clr(input logic [1:0] d);
    clr_en = 1'b1; clr_data = d;
    @(negedge clk);
    clr_en = 1'b0; clr_data = 2'b11;
  endtask

  task automatic hit(input logic [1:0] m);
    alm1_hit = m[0]; alm2_hit = m[1];
    @(negedge clk);
    alm1_hit = 1'b0; alm2_hit = 1'b0;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      ref_tick = 1'b1;
      @(negedge clk);
      ref_tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    chk("R1", "ctrl", 32'(ctrl_rd), 32'h1C);
    chk("R1", "flags", 32'({flag_a2, flag_a1}), 32'h0);
    chk("R1", "pin_n", 32'(pin_n), 32'h1);
    chk("R1", "pin_oe", 32'(pin_oe), 32'h1);
  endtask

  task automatic t_rw;
    wr_ctrl(8'hA5);
    chk("R2", "readback A5", 32'(ctrl_rd), 32'hA5);
    wr_ctrl(8'h5A);
    chk("R2", "readback 5A", 32'(ctrl_rd), 32'h5A);
  endtask

  task automatic t_rate(input logic [1:0] rs, input int half);
    int n;
    wr_ctrl({3'b000, rs, 3'b000});
    chk("R10", "high after restart", 32'(pin_n), 32'h1);
    n = 0;
    while (pin_n && n < 20000) begin ticks(1); n++; end
    chk("R3", $sformatf("high ticks rs=%0d", rs), 32'(n), 32'(half));
    n = 0;
    while (!pin_n && n < 20000) begin ticks(1); n++; end
    chk("R3", $sformatf("low ticks rs=%0d", rs), 32'(n), 32'(half));
  endtask

  task automatic t_sqw_mode;
    clr(2'b00);
    wr_ctrl(8'h1B);
    hit(2'b11);
    chk("R6", "flags set in wave mode", 32'({flag_a2, flag_a1}), 32'h3);
    chk("R4", "pin high ignoring flags", 32'(pin_n), 32'h1);
    ticks(2);
    chk("R4", "pin follows wave low", 32'(pin_n), 32'h0);
    ticks(2);
    chk("R4", "pin follows wave high", 32'(pin_n), 32'h1);
  endtask

  task automatic t_irq;
    wr_ctrl(8'h04);
    clr(2'b00);
    chk("R7", "flags cleared", 32'({flag_a2, flag_a1}), 32'h0);
    hit(2'b01);
    chk("R6", "a1 set", 32'({flag_a2, flag_a1}), 32'h1);
    chk("R5", "no enable no irq", 32'(pin_n), 32'h1);
    wr_ctrl(8'h05);
    chk("R5", "a1 enabled irq", 32'(pin_n), 32'h0);
    wr_ctrl(8'h06);
    chk("R5", "a2 enable with a1 flag only", 32'(pin_n), 32'h1);
    hit(2'b10);
    chk("R5", "a2 enabled irq", 32'(pin_n), 32'h0);
    clr(2'b10);
    chk("R7", "clear a1 only", 32'({flag_a2, flag_a1}), 32'h2);
    chk("R5", "a2 still asserts", 32'(pin_n), 32'h0);
    clr(2'b01);
    chk("R7", "clear a2", 32'({flag_a2, flag_a1}), 32'h0);
    chk("R5", "released", 32'(pin_n), 32'h1);
    alm1_hit = 1'b1; clr_en = 1'b1; clr_data = 2'b00;
    @(negedge clk);
    alm1_hit = 1'b0; clr_en = 1'b0; clr_data = 2'b11;
    chk("R7", "set wins over clear", 32'({flag_a2, flag_a1}), 32'h1);
    clr(2'b00);
  endtask

  task automatic t_battery;
    wr_ctrl(8'h05);
    on_battery = 1'b1;
    @(negedge clk);
    chk("R8", "oe off on battery", 32'(pin_oe), 32'h0);
    chk("R8", "pin idle high", 32'(pin_n), 32'h1);
    on_battery = 1'b0;
    wr_ctrl(8'h45);
    hit(2'b01);
    on_battery = 1'b1;
    @(negedge clk);
    chk("R8", "oe kept with drive bit", 32'(pin_oe), 32'h1);
    chk("R8", "irq drives on battery", 32'(pin_n), 32'h0);
    on_battery = 1'b0;
    @(negedge clk);
    clr(2'b00);
  endtask

  task automatic t_freeze;
    wr_ctrl(8'hD8);
    on_battery = 1'b1;
    @(negedge clk);
    ticks(3);
    chk("R9", "divider frozen", 32'(pin_n), 32'h1);
    hit(2'b11);
    chk("R9", "matches ignored", 32'({flag_a2, flag_a1}), 32'h0);
    wr_ctrl(8'h1C);
    chk("R9", "write ignored", 32'(ctrl_rd), 32'hD8);
    on_battery = 1'b0;
    @(negedge clk);
    ticks(2);
    chk("R9", "mains runs with stop bit", 32'(pin_n), 32'h0);
  endtask

  task automatic t_restart;
    wr_ctrl(8'h08);
    ticks(10);
    chk("R10", "mid count high", 32'(pin_n), 32'h1);
    wr_ctrl(8'h18);
    ticks(1);
    chk("R10", "full count after restart", 32'(pin_n), 32'h1);
    ticks(1);
    chk("R10", "toggle after restart", 32'(pin_n), 32'h0);
    ticks(2);
    chk("R10", "back high", 32'(pin_n), 32'h1);
    ticks(1);
    wr_ctrl(8'h19);
    ticks(1);
    chk("R10", "enable-only write keeps phase", 32'(pin_n), 32'h0);
  endtask

  initial begin
    #2000000;
    bad_cnt++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_rw();
    t_rate(2'b11, 2);
    t_rate(2'b10, 4);
    t_rate(2'b01, 16);
    t_rate(2'b00, 16384);
    t_sqw_mode();
    t_irq();
    t_battery();
    t_freeze();
    t_restart();
    $display("== %0d vectors applied, %0d miscompares ==", vec_cnt, bad_cnt);
    $finish;
  end

endmodule